// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is a synchronous target for a 32-bit bus that carries the address and the data on the same wires. A transaction opens with an address phase, in which the four command/byte-enable lines carry the command. The target decodes that address against a fixed window and latches the word index and the direction. Every later clock is a data phase, served from or into a small internal word array. During data phases the command lines carry active-low byte enables.

Each data phase is a two-sided valid/ready exchange. The initiator's ready (`irdy_n`, active low) means it has put write data on the bus or can take read data. The target's ready (`trdy_n`, active low) means it has taken or driven the word. A word moves only on a rising edge where both are low. Either side applies back-pressure by holding its ready high: the target then holds its read word steady, and a write word is not stored. The initiator keeps `frame_n` low while more phases follow and raises it for the final phase. The target then returns to idle after that word moves. Consecutive words go to consecutive array entries.

Even parity covers the 32 address/data lines and the 4 command/byte-enable lines. It travels one clock behind the values it covers. The target drives it for the words it returns and checks it for the words it receives.

Top module: `mux_bus_target`

## Requirements
- R1: While reset is low and in the first cycle after it, `trdy_n` is 1, `ad_oe`, `par_oe` and `perr` are 0, and every array word reads back as 0.
- R2: A transaction is accepted only for command 4'b0111 (write) or 4'b0110 (read) with `ad_in[31:2+AW]` equal to the same bits of `BASE_ADDR`. Any other command or address leaves `trdy_n` high and `ad_oe` low until `frame_n` and `irdy_n` are both high, and changes no array word. `AW` is the log2 of `DEPTH`.
- R3: On an accepted write, `trdy_n` goes low in the cycle after the address phase and stays low while `frame_n` is low. On each edge with both readies low, byte n of `ad_in` is stored into the current word only if `cbe_n[n]` is 0.
- R4: A write data phase with `cbe_n` = 4'b1111 still completes the handshake, but it changes no byte of the array.
- R5: On an accepted read, `trdy_n` stays high for the first cycle after the address phase. It goes low in the second cycle, with `ad_oe` high and `ad_out` holding the addressed word.
- R6: While `trdy_n` is low on a read and `irdy_n` is high, the next cycle keeps `trdy_n` low and `ad_out` unchanged.
- R7: An edge with both readies low and `frame_n` high is the final transfer. In the next cycle `trdy_n` is 1 and `ad_oe` is 0.
- R8: After each transfer that is not the final one, the word index rises by one and wraps from `DEPTH-1` to 0 within the window.
- R9: In the cycle after any cycle with `ad_oe` high, `par_oe` is 1 and `par_out` equals the XOR of that earlier cycle's `ad_out` and `cbe_n`.
- R10: For each write transfer, `par_in` is sampled one cycle later against the XOR of that transfer's `ad_in` and `cbe_n`. On a mismatch, `perr` is 1 in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Low from the address phase until the final data phase |
| irdy_n | input | 1 | Initiator ready, active low |
| ad_in | input | 32 | Address/data from the initiator |
| cbe_n | input | 4 | Command in address phase, active-low byte enables in data phases |
| par_in | input | 1 | Even parity from the initiator, one clock late |
| trdy_n | output | 1 | Target ready, active low |
| ad_out | output | 32 | Read data driven by the target |
| ad_oe | output | 1 | Target is driving `ad_out` |
| par_out | output | 1 | Even parity for driven read data, one clock late |
| par_oe | output | 1 | Target is driving `par_out` |
| perr | output | 1 | One-cycle parity error pulse on received write data |

## Verification
Single-word writes followed by reads use all-enabled, single-lane and alternating-lane byte masks. These show whether each enable bit gates its own lane and whether the polarity is right. Four-word bursts with a held-off initiator ready show whether the index advances only on completed handshakes and whether read data is held. A burst that starts at the top entry exposes a wrap that is missing or wrong. Addresses one window above the base and a non-memory command must both be ignored. Reading back the aliased word makes any hidden write visible. Deliberately flipped parity on a write must raise a single-cycle error flag.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_RD_WAIT,
    ST_READ,
    ST_SKIP
  } mbt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/mbt_decode.sv
module mbt_decode #(
  parameter logic [31:0] BASE_ADDR = 32'h0000_4000,
  parameter int          AW        = 4
) (
  input  logic [31:0]   addr,
  input  logic [3:0]    cmd,
  output logic          hit_rd,
  output logic          hit_wr,
  output logic [AW-1:0] word_idx
);
  import mbt_pkg::*;

  logic in_window;

  assign in_window = (addr[31:AW+2] == BASE_ADDR[31:AW+2]);
  assign hit_rd    = in_window && (cmd == CMD_MEM_RD);
  assign hit_wr    = in_window && (cmd == CMD_MEM_WR);
  assign word_idx  = addr[AW+1:2];
endmodule

// File: rtl/mbt_store.sv
module mbt_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [3:0]    be_n,
  input  logic [AW-1:0] widx,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] ridx,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  for (genvar b = 0; b < 4; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int w = 0; w < DEPTH; w++) mem[w][8*b +: 8] <= 8'h00;
      end else if (we && !be_n[b]) begin
        mem[widx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/mbt_parity.sv
module mbt_parity (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        drive_en,
  input  logic [31:0] ad_drv,
  input  logic [31:0] ad_rx,
  input  logic [3:0]  cbe_n,
  input  logic        chk_en,
  input  logic        par_in,
  output logic        par_out,
  output logic        par_oe,
  output logic        perr
);
  logic chk_pend;
  logic chk_exp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_out  <= 1'b0;
      par_oe   <= 1'b0;
      chk_pend <= 1'b0;
      chk_exp  <= 1'b0;
      perr     <= 1'b0;
    end else begin
      par_out  <= (^ad_drv) ^ (^cbe_n);
      par_oe   <= drive_en;
      chk_pend <= chk_en;
      chk_exp  <= (^ad_rx) ^ (^cbe_n);
      perr     <= chk_pend && (par_in != chk_exp);
    end
  end
endmodule

// File: rtl/mux_bus_target.sv
module mux_bus_target #(
  parameter logic [31:0] BASE_ADDR = 32'h0000_4000,
  parameter int          DEPTH     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  input  logic        par_in,
  output logic        trdy_n,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        par_out,
  output logic        par_oe,
  output logic        perr
);
  import mbt_pkg::*;

  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] IDX_ONE = 1;

  mbt_state_e    state;
  logic [AW-1:0] idx;
  logic [AW-1:0] idx_next;
  logic [AW-1:0] ridx;
  logic [AW-1:0] dec_idx;
  logic          hit_rd, hit_wr;
  logic          xfer;
  logic          wr_xfer;
  logic [31:0]   rdata;

  assign xfer     = !irdy_n && !trdy_n;
  assign wr_xfer  = (state == ST_WRITE) && xfer;
  assign idx_next = idx + IDX_ONE;
  assign ridx     = (state == ST_READ) ? idx_next : idx;

  mbt_decode #(.BASE_ADDR(BASE_ADDR), .AW(AW)) u_dec (
    .addr     (ad_in),
    .cmd      (cbe_n),
    .hit_rd   (hit_rd),
    .hit_wr   (hit_wr),
    .word_idx (dec_idx)
  );

  mbt_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_xfer),
    .be_n  (cbe_n),
    .widx  (idx),
    .wdata (ad_in),
    .ridx  (ridx),
    .rdata (rdata)
  );

  mbt_parity u_par (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive_en (ad_oe),
    .ad_drv   (ad_out),
    .ad_rx    (ad_in),
    .cbe_n    (cbe_n),
    .chk_en   (wr_xfer),
    .par_in   (par_in),
    .par_out  (par_out),
    .par_oe   (par_oe),
    .perr     (perr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      trdy_n <= 1'b1;
      ad_out <= '0;
      ad_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!frame_n) begin
            idx <= dec_idx;
            if (hit_wr) begin
              state  <= ST_WRITE;
              trdy_n <= 1'b0;
            end else if (hit_rd) begin
              state <= ST_RD_WAIT;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_WRITE: begin
          if (xfer) begin
            idx <= idx_next;
            if (frame_n) begin
              trdy_n <= 1'b1;
              state  <= ST_IDLE;
            end
          end
        end
        ST_RD_WAIT: begin
          ad_out <= rdata;
          ad_oe  <= 1'b1;
          trdy_n <= 1'b0;
          state  <= ST_READ;
        end
        ST_READ: begin
          if (xfer) begin
            if (frame_n) begin
              trdy_n <= 1'b1;
              ad_oe  <= 1'b0;
              state  <= ST_IDLE;
            end else begin
              idx    <= idx_next;
              ad_out <= rdata;
            end
          end
        end
        ST_SKIP: begin
          if (frame_n && irdy_n) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbt_checker.sv
module mbt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_n,
  input logic        irdy_n,
  input logic [3:0]  cbe_n,
  input logic        trdy_n,
  input logic [31:0] ad_out,
  input logic        ad_oe,
  input logic        par_out,
  input logic        par_oe,
  input logic        perr
);
  // R3: a write target stays ready while more phases follow
  assert_write_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !ad_oe && !frame_n) |=> !trdy_n);

  // R6: read word held while the initiator stalls
  assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n && ad_oe) |=> (!trdy_n && $stable(ad_out)));

  // R7: final transfer releases the bus
  assert_final_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !trdy_n && frame_n) |=> (trdy_n && !ad_oe));

  // R9: driven parity follows driven data by one clock
  assert_read_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |=> (par_oe && (par_out == ((^$past(ad_out)) ^ (^$past(cbe_n))))));

  // R10: an error pulse only follows a received write word
  assert_perr_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    perr |-> $past(!irdy_n && !trdy_n && !ad_oe, 2));
endmodule

bind mux_bus_target mbt_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .frame_n (frame_n),
  .irdy_n  (irdy_n),
  .cbe_n   (cbe_n),
  .trdy_n  (trdy_n),
  .ad_out  (ad_out),
  .ad_oe   (ad_oe),
  .par_out (par_out),
  .par_oe  (par_oe),
  .perr    (perr)
);

// File: tb/mux_bus_target_test.sv
`timescale 1ns/1ps
module mux_bus_target_test;
  localparam logic [31:0] BASE = 32'h0000_4000;
  localparam int          NVEC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        par_in = 1'b0;
  logic        trdy_n, ad_oe, par_out, par_oe, perr;
  logic [31:0] ad_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mux_bus_target #(.BASE_ADDR(BASE), .DEPTH(16)) uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad_in(ad_in), .cbe_n(cbe_n), .par_in(par_in), .trdy_n(trdy_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
    .perr(perr)
  );

  // vector: {is_write, word index, be_n, write data, expected read}
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b1, 4'd2,  4'b0000, 32'h1122_3344, 32'h0},
    {1'b0, 4'd2,  4'b0000, 32'h0,         32'h1122_3344},
    {1'b1, 4'd2,  4'b1110, 32'hAAAA_AA55, 32'h0},
    {1'b0, 4'd2,  4'b0000, 32'h0,         32'h1122_3355},
    {1'b1, 4'd2,  4'b0101, 32'h9988_7766, 32'h0},
    {1'b0, 4'd2,  4'b0000, 32'h0,         32'h9922_7755},
    {1'b1, 4'd15, 4'b0000, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 4'd15, 4'b0000, 32'h0,         32'hDEAD_BEEF}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] addr, input int n, input logic [31:0] d0,
                          input logic [3:0] be, input bit bad_last);
    logic pp;
    pp = 1'b0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = 4'b0111; par_in = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      par_in  = pp;
      ad_in   = d0 + 32'(i);
      cbe_n   = be;
      irdy_n  = 1'b0;
      frame_n = (i == n - 1);
      pp = (^ad_in) ^ (^be) ^ ((i == n - 1) ? bad_last : 1'b0);
      check(trdy_n == 1'b0, "R3 write ready", {31'b0, trdy_n}, 32'h0);
    end
    @(negedge clk);
    irdy_n = 1'b1; frame_n = 1'b1; par_in = pp; ad_in = '0; cbe_n = 4'hF;
    check(trdy_n == 1'b1, "R7 write release", {31'b0, trdy_n}, 32'h1);
    @(negedge clk);
    par_in = 1'b0;
    check(perr == bad_last, "R10 perr", {31'b0, perr}, {31'b0, bad_last});
  endtask

  task automatic do_read(input logic [31:0] addr, input int n, input logic [31:0] e0,
                         input bit stall);
    logic [31:0] last;
    last = e0;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = 4'b0110;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_n = (i == n - 1);
      irdy_n  = 1'b0;
      cbe_n   = 4'b0000;
      ad_in   = '0;
      if (i == 0) begin
        check(trdy_n == 1'b1, "R5 wait state", {31'b0, trdy_n}, 32'h1);
        @(negedge clk);
        check(trdy_n == 1'b0 && ad_oe, "R5 data ready", {30'b0, ad_oe, trdy_n}, 32'h2);
      end
      last = e0 + 32'(i);
      check(ad_out == last, "R5/R8 read data", ad_out, last);
      if (stall && i == 1) begin
        irdy_n = 1'b1;
        @(negedge clk);
        check(trdy_n == 1'b0 && ad_out == last, "R6 stall hold", ad_out, last);
        irdy_n = 1'b0;
      end
    end
    @(negedge clk);
    irdy_n = 1'b1; frame_n = 1'b1; cbe_n = 4'hF;
    check(trdy_n == 1'b1 && !ad_oe, "R7 read release", {30'b0, ad_oe, trdy_n}, 32'h1);
    check(par_oe && par_out == ^last, "R9 read parity", {30'b0, par_oe, par_out},
          {30'b0, 1'b1, ^last});
  endtask

  task automatic do_ignored(input logic [31:0] addr, input logic [3:0] cmd);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      frame_n = 1'b1; irdy_n = 1'b0; ad_in = 32'hFFFF_FFFF; cbe_n = 4'b0000;
      check(trdy_n == 1'b1 && !ad_oe, "R2 ignored", {30'b0, ad_oe, trdy_n}, 32'h1);
    end
    @(negedge clk);
    irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(trdy_n && !ad_oe && !par_oe && !perr, "R1 in reset",
          {28'b0, trdy_n, ad_oe, par_oe, perr}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(trdy_n && !ad_oe && !par_oe && !perr, "R1 after reset",
          {28'b0, trdy_n, ad_oe, par_oe, perr}, 32'h8);
    do_read(BASE + 32'd20, 1, 32'h0, 1'b0); // R1 cleared array

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][72])
        do_write(BASE + {26'b0, VEC[v][71:68], 2'b00}, 1, VEC[v][63:32], VEC[v][67:64], 1'b0);
      else
        do_read(BASE + {26'b0, VEC[v][71:68], 2'b00}, 1, VEC[v][31:0], 1'b0);
    end

    // R8 burst and R6 stall
    do_write(BASE + 32'd16, 4, 32'h1000_0000, 4'b0000, 1'b0);
    do_read(BASE + 32'd16, 4, 32'h1000_0000, 1'b1);

    // R8 wrap from the top entry
    do_write(BASE + 32'd60, 2, 32'h5A00_0000, 4'b0000, 1'b0);
    do_read(BASE + 32'd60, 2, 32'h5A00_0000, 1'b0);
    do_read(BASE, 1, 32'h5A00_0001, 1'b0);

    // R4 null data phase
    do_write(BASE + 32'd16, 1, 32'hFFFF_FFFF, 4'b1111, 1'b0);
    do_read(BASE + 32'd16, 1, 32'h1000_0000, 1'b0);

    // R2 outside window (would alias word 0) and non-memory command
    do_ignored(BASE + 32'h40, 4'b0111);
    do_read(BASE, 1, 32'h5A00_0001, 1'b0);
    do_ignored(BASE + 32'd4, 4'b0011);
    do_read(BASE + 32'd4, 1, 32'h0, 1'b0);

    // R10 parity error pulse lasts one cycle
    do_write(BASE + 32'd12, 1, 32'h0F0F_1234, 4'b0000, 1'b1);
    @(negedge clk);
    check(perr == 1'b0, "R10 single pulse", {31'b0, perr}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule